// File: doc/BRIEF.md
# Variable-Latency Shared Multiplier

This block is the one integer multiplier shared by the execute stage of a simple in-order pipeline. It takes three kinds of request. The first is a signed 16x16 halfword product. The second is a 32x32 product that keeps only the low word. The third is a 32x32 long product that returns all 64 bits, either signed or unsigned. Each kind holds the unit for its own number of issue cycles. After that, each result word arrives on its own schedule. The two words of a long product come back one cycle apart.

Requests use a valid/ready handshake and carry an opcode, a sign-mode bit, two operands and a small tag. The `busy` output tells the pipeline that the unit is still inside the issue cycles of an earlier operation. Results leave on two strobed channels, one for the low word and one for the high word. Each strobe lasts one cycle and carries the tag of its request. Results always leave in the order the requests were accepted. Internally, the product is the sum of shifted copies of the multiplicand, one copy for each set bit of the multiplier.

Top module: `mac_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `lo_valid` and `hi_valid` are all 0.
- R2: Opcode 00 is the halfword multiply. It uses bits [15:0] of both operands as signed values and returns their full product, sign-extended to 32 bits, on the low channel. If the request is accepted in cycle t, `lo_valid` pulses in cycle t+3. The unit takes a new request in cycle t+1.
- R3: Opcode 01 is the word multiply. It returns the low 32 bits of a*b on the low channel in cycle t+4. `busy` is 1 in cycle t+1.
- R4: Opcode 10 or 11 is the long multiply. `busy` is 1 in cycles t+1 and t+2. The low word arrives on the low channel in cycle t+6. The high word arrives on the high channel in cycle t+7, with the same tag.
- R5: For a long multiply, `req_signed`=1 treats both operands as two's complement and `req_signed`=0 treats them as unsigned. The bit is ignored for the other opcodes.
- R6: While `busy` is 1, `req_ready` is 0, and a request presented in that cycle is not accepted and produces no result.
- R7: A request is accepted in the first cycle after the last issue cycle, even while earlier results are still in flight.
- R8: Results leave in acceptance order. Each result is a single-cycle strobe carrying the tag of its request.
- R9: If a request's low word would land in the same cycle as a low word already scheduled, `req_ready` is 0 in that cycle. This happens only for a halfword request three cycles after a long multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take the request this cycle |
| req_op | input | 2 | 00 halfword, 01 word, 1x long |
| req_signed | input | 1 | Sign mode for long multiply |
| req_id | input | ID_W | Request tag |
| req_a | input | 32 | Multiplicand |
| req_b | input | 32 | Multiplier |
| busy | output | 1 | Unit is inside issue cycles |
| lo_valid | output | 1 | Low-word result strobe |
| lo_id | output | ID_W | Tag of low-word result |
| lo_data | output | 32 | Low-word result |
| hi_valid | output | 1 | High-word result strobe |
| hi_id | output | ID_W | Tag of high-word result |
| hi_data | output | 32 | High-word result |

## Verification
Several properties are checked on every cycle:
- `busy` keeps `req_ready` low.
- Each opcode holds `busy` for exactly its issue window.
- A halfword result strobe follows its acceptance after three cycles.
- A high-word strobe always follows the low-word strobe of the same tag by one cycle.

Other behaviour can only be shown by the bench scenarios, which compare against a reference model:
- the arithmetic for negative, extreme and unsigned operands;
- the refusal of a halfword request that would collide with a long multiply's low word;
- that results leave in order under dense random traffic.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int ID_W      = 4,
  parameter int HALF_OCC  = 1,
  parameter int WORD_OCC  = 2,
  parameter int LONG_OCC  = 3,
  parameter int HALF_LAT  = 3,
  parameter int WORD_LAT  = 3,
  parameter int LO_LAT    = 4,
  parameter int HI_LAT    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic            req_signed,
  input  logic [ID_W-1:0] req_id,
  input  logic [31:0]     req_a,
  input  logic [31:0]     req_b,
  output logic            busy,
  output logic            lo_valid,
  output logic [ID_W-1:0] lo_id,
  output logic [31:0]     lo_data,
  output logic            hi_valid,
  output logic [ID_W-1:0] hi_id,
  output logic [31:0]     hi_data
);
  localparam int HALF_D = HALF_OCC - 1 + HALF_LAT;
  localparam int WORD_D = WORD_OCC - 1 + WORD_LAT;
  localparam int LO_D   = LONG_OCC - 1 + LO_LAT;
  localparam int HI_D   = LONG_OCC - 1 + HI_LAT;
  localparam int DEPTH  = HI_D + 1;
  localparam int CW     = $clog2(LONG_OCC + 1);

  logic [CW-1:0]   occ_cnt;
  logic [DEPTH-1:0] lo_v, hi_v;
  logic [31:0]     lo_d [DEPTH];
  logic [31:0]     hi_d [DEPTH];
  logic [ID_W-1:0] lo_t [DEPTH];
  logic [ID_W-1:0] hi_t [DEPTH];

  wire is_half = (req_op == 2'b00);
  wire is_word = (req_op == 2'b01);
  wire is_long = req_op[1];

  int dlo;
  always_comb begin
    if (is_half)      dlo = HALF_D;
    else if (is_word) dlo = WORD_D;
    else              dlo = LO_D;
  end

  assign busy      = (occ_cnt != '0);
  assign req_ready = !busy && !lo_v[dlo];
  wire   fire      = req_valid && req_ready;

  function automatic logic [63:0] shift_add(input logic [31:0] x, input logic [31:0] y);
    logic [63:0] acc;
    acc = '0;
    for (int i = 0; i < 32; i++)
      acc = acc + (y[i] ? ({32'b0, x} << i) : 64'b0);
    return acc;
  endfunction

  wire [31:0] op_a = is_half ? {{16{req_a[15]}}, req_a[15:0]} : req_a;
  wire [31:0] op_b = is_half ? {{16{req_b[15]}}, req_b[15:0]} : req_b;
  wire        sgn  = is_half || (is_long && req_signed);
  wire        neg_a = sgn && op_a[31];
  wire        neg_b = sgn && op_b[31];
  wire [31:0] mag_a = neg_a ? (~op_a + 32'd1) : op_a;
  wire [31:0] mag_b = neg_b ? (~op_b + 32'd1) : op_b;
  wire [63:0] mag_p = shift_add(mag_a, mag_b);
  wire [63:0] prod  = (neg_a ^ neg_b) ? (~mag_p + 64'd1) : mag_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_cnt <= '0;
      lo_v    <= '0;
      hi_v    <= '0;
    end else begin
      lo_v <= lo_v >> 1;
      hi_v <= hi_v >> 1;
      if (fire) begin
        lo_v[dlo-1] <= 1'b1;
        if (is_long) hi_v[HI_D-1] <= 1'b1;
        occ_cnt <= is_half ? CW'(HALF_OCC - 1) : is_word ? CW'(WORD_OCC - 1) : CW'(LONG_OCC - 1);
      end else if (busy) begin
        occ_cnt <= occ_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH - 1; k++) begin
      lo_d[k] <= lo_d[k+1];
      lo_t[k] <= lo_t[k+1];
      hi_d[k] <= hi_d[k+1];
      hi_t[k] <= hi_t[k+1];
    end
    lo_d[DEPTH-1] <= '0;
    lo_t[DEPTH-1] <= '0;
    hi_d[DEPTH-1] <= '0;
    hi_t[DEPTH-1] <= '0;
    if (fire) begin
      lo_d[dlo-1] <= prod[31:0];
      lo_t[dlo-1] <= req_id;
      if (is_long) begin
        hi_d[HI_D-1] <= prod[63:32];
        hi_t[HI_D-1] <= req_id;
      end
    end
  end

  assign lo_valid = lo_v[0];
  assign lo_data  = lo_d[0];
  assign lo_id    = lo_t[0];
  assign hi_valid = hi_v[0];
  assign hi_data  = hi_d[0];
  assign hi_id    = hi_t[0];

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  assert_half_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b00) |-> ##3 lo_valid);
  assert_word_occupancy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b01) |=> busy ##1 !busy);
  assert_long_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op[1]) |=> busy ##1 busy ##1 !busy);
  assert_hi_follows_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_valid |-> ($past(lo_valid) && hi_id == $past(lo_id)));
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
  localparam int ID_W = 4;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_signed = 0;
  logic [1:0] req_op = 0;
  logic [ID_W-1:0] req_id = 0;
  logic [31:0] req_a = 0, req_b = 0;
  logic req_ready, busy, lo_valid, hi_valid;
  logic [ID_W-1:0] lo_id, hi_id;
  logic [31:0] lo_data, hi_data;

  mac_unit #(.ID_W(ID_W)) i_mac_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_signed(req_signed), .req_id(req_id), .req_a(req_a),
    .req_b(req_b), .busy(busy), .lo_valid(lo_valid), .lo_id(lo_id),
    .lo_data(lo_data), .hi_valid(hi_valid), .hi_id(hi_id), .hi_data(hi_data));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, free_at = 0;
  bit done = 0;
  logic [31:0] exp_lo_d [int];
  logic [ID_W-1:0] exp_lo_i [int];
  string exp_lo_t [int];
  logic [31:0] exp_hi_d [int];
  logic [ID_W-1:0] exp_hi_i [int];
  string exp_hi_t [int];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input logic [1:0] op, input bit s, input logic [31:0] a, input logic [31:0] b);
    logic signed [31:0] ha, hb, hp;
    logic signed [63:0] la, lb;
    ha = $signed(a[15:0]);
    hb = $signed(b[15:0]);
    la = $signed(a);
    lb = $signed(b);
    hp = ha * hb;
    if (op == 2'b00) return {32'b0, hp};
    if (op == 2'b01) return {32'b0, a * b};
    if (s) return la * lb;
    return {32'b0, a} * {32'b0, b};
  endfunction

  task automatic step(input bit v, input logic [1:0] op, input bit s, input logic [ID_W-1:0] id,
                      input logic [31:0] a, input logic [31:0] b, output bit acc);
    int dl, occ;
    bit er, lo_e, hi_e;
    string rt;
    @(negedge clk);
    lo_e = exp_lo_d.exists(cyc);
    chk(lo_valid == lo_e, lo_e ? exp_lo_t[cyc] : "R8", {63'b0, lo_valid}, {63'b0, lo_e});
    if (lo_e && lo_valid) begin
      chk(lo_data == exp_lo_d[cyc], exp_lo_t[cyc], {32'b0, lo_data}, {32'b0, exp_lo_d[cyc]});
      chk(lo_id == exp_lo_i[cyc], "R8", {60'b0, lo_id}, {60'b0, exp_lo_i[cyc]});
    end
    hi_e = exp_hi_d.exists(cyc);
    chk(hi_valid == hi_e, hi_e ? exp_hi_t[cyc] : "R4", {63'b0, hi_valid}, {63'b0, hi_e});
    if (hi_e && hi_valid) begin
      chk(hi_data == exp_hi_d[cyc], exp_hi_t[cyc], {32'b0, hi_data}, {32'b0, exp_hi_d[cyc]});
      chk(hi_id == exp_hi_i[cyc], "R4", {60'b0, hi_id}, {60'b0, exp_hi_i[cyc]});
    end
    req_valid = v; req_op = op; req_signed = s; req_id = id; req_a = a; req_b = b;
    #1;
    dl  = (op == 2'b00) ? 3 : (op == 2'b01) ? 4 : 6;
    occ = (op == 2'b00) ? 1 : (op == 2'b01) ? 2 : 3;
    er  = (cyc >= free_at) && !exp_lo_d.exists(cyc + dl);
    rt  = (cyc < free_at) ? "R6" : (exp_lo_d.exists(cyc + dl) ? "R9" : "R7");
    chk(req_ready == er, rt, {63'b0, req_ready}, {63'b0, er});
    chk(busy == (cyc < free_at), "R6", {63'b0, busy}, {63'b0, (cyc < free_at)});
    acc = v && er;
    if (acc) begin
      logic [63:0] p;
      p = ref_prod(op, s, a, b);
      free_at = cyc + occ;
      exp_lo_d[cyc + dl] = p[31:0];
      exp_lo_i[cyc + dl] = id;
      exp_lo_t[cyc + dl] = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R3" : "R5";
      if (op[1]) begin
        exp_hi_d[cyc + 7] = p[63:32];
        exp_hi_i[cyc + 7] = id;
        exp_hi_t[cyc + 7] = "R5";
      end
    end
    cyc++;
  endtask

  task automatic send(input logic [1:0] op, input bit s, input logic [ID_W-1:0] id,
                      input logic [31:0] a, input logic [31:0] b);
    bit acc;
    acc = 0;
    while (!acc) step(1, op, s, id, a, b, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(0, 2'b00, 0, '0, '0, '0, acc);
  endtask

  initial begin
    bit acc;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", {63'b0, req_ready}, 64'd1);
    chk(busy == 0, "R1", {63'b0, busy}, 64'd0);
    chk(lo_valid == 0 && hi_valid == 0, "R1", {62'b0, lo_valid, hi_valid}, 64'd0);
    idle(2);
    send(2'b00, 0, 4'd1, 32'hFFFF_8000, 32'h0000_0003);
    idle(5);
    send(2'b00, 1, 4'd2, 32'h1234_7FFF, 32'hABCD_7FFF);
    send(2'b00, 0, 4'd3, 32'h0000_FFFF, 32'h0000_8000);
    idle(5);
    send(2'b01, 0, 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(1, 2'b00, 0, 4'd15, 32'h5, 32'h5, acc);
    chk(acc == 0, "R6", {63'b0, acc}, 64'd0);
    send(2'b01, 1, 4'd5, 32'h8000_0000, 32'h0000_0003);
    idle(6);
    send(2'b10, 0, 4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle(8);
    send(2'b11, 1, 4'd7, 32'h8000_0000, 32'h8000_0000);
    send(2'b10, 1, 4'd8, 32'hFFFF_FFFF, 32'h0000_0005);
    send(2'b00, 0, 4'd9, 32'h0000_0007, 32'h0000_FFFE);
    send(2'b01, 0, 4'd10, 32'hDEAD_BEEF, 32'h1234_5678);
    send(2'b10, 0, 4'd11, 32'h8000_0000, 32'h8000_0000);
    idle(10);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] != 0, r[4:3], r[5], r[9:6], $urandom, $urandom, acc);
    end
    idle(10);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule